// File: doc/BRIEF.md
# Programmable Clock Output Router

This block is the digital output stage of a programmable clock generator. It runs on one system clock and receives the reference clock and the synthesized PLL clock as single-cycle edge strobes. Each strobe marks one half-period edge of its source. From these it builds divided square waves. The main output is chosen from the PLL divided by twice a 5-bit post-divider, the raw reference, or the reference divided by the same even ratio. A second output is chosen from the reference, the reference halved, the main output, or the main output halved.

Two configuration sets sit in registers, and a frequency-select input picks one of them at run time. A multi-purpose pin serves one role at a time. It can be an output-enable input, a power-down input, or the driver of the second clock. Every switch of configuration, enable or power state waits for a low phase, so the outputs never show a shortened pulse.

A parallel write port loads the two sets and the pin role. Set fields are {sel1[8:7], sel0[6:5], div[4:0]}.

Top module: `clk_out_router`

## Requirements
- R1: After reset, `clk0_o`, `mpin_out` and `mpin_oe` are 0. Both sets hold div=1, sel0=0, sel1=0. The pin role is enable, and both synchronized inputs read as 1.
- R2: sel0 picks the main source. 0 (and 3) selects the PLL divided by 2*div, 1 selects the raw reference, and 2 selects the reference divided by 2*div. The output half-period is 2*div source strobes, or 1 strobe for the raw reference.
- R3: The post-divider ratio is always even. A div of 0 behaves as div=1.
- R4: sel1 picks the second source. 0 is the reference, 1 is the reference halved, 2 is the main output, and 3 is the main output halved. The result drives `mpin_out` when the pin role is clock.
- R5: `fsel`=1 selects set 0 and `fsel`=0 selects set 1. `fsel` passes through two synchronizing flops before use.
- R6: A new configuration takes effect only in a cycle where both internal outputs are low. All divider state then restarts from zero.
- R7: In enable role (role code 0 or 3), `mpin_in`=0 forces both outputs low. The gate opens or closes only while the affected output is low.
- R8: In power-down role (code 1), `mpin_in`=0 stops and clears all counters once the outputs are low. The outputs then stay low until `mpin_in` returns to 1.
- R9: Writes to address 0 load set 0 and writes to address 1 load set 1. Writes to address 2 load the pin role from data bits [1:0]. Address 3 is ignored.
- R10: `mpin_oe` is 1 only in clock role (code 2). In that role `mpin_in` has no effect. In the other roles `mpin_out` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | Reference half-period strobe |
| pll_tick | input | 1 | PLL half-period strobe |
| fsel | input | 1 | Configuration set select |
| mpin_in | input | 1 | Multi-purpose pin input value |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 9 | Register write data |
| clk0_o | output | 1 | Main clock output |
| mpin_out | output | 1 | Multi-purpose pin drive value |
| mpin_oe | output | 1 | Multi-purpose pin drive enable |

## Verification
A wrong divider count or a wrong source choice shows up as a wrong output period within one output period of the change. The bench measures periods for every source code on both sets. A wrong gate or run flag shows as a pulse that is too short or too long, or as a missing low hold. This appears within the two synchronizer cycles plus the remainder of the current half-period. The behavioural model compares every cycle, so an off-by-one in the synchronizers or in the restart rule appears on the first divergent edge.

// File: rtl/clk_out_router.sv
module clk_out_router #(
  parameter int PW = 5,
  parameter int SW = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ref_tick,
  input  logic                pll_tick,
  input  logic                fsel,
  input  logic                mpin_in,
  input  logic                wr_en,
  input  logic [1:0]          wr_addr,
  input  logic [PW+2*SW-1:0]  wr_data,
  output logic                clk0_o,
  output logic                mpin_out,
  output logic                mpin_oe
);
  localparam int CFGW = PW + 2*SW;
  localparam int CW   = PW + 2;
  localparam logic [1:0] ROLE_PD = 2'd1, ROLE_CK = 2'd2;
  localparam logic [CFGW-1:0] CFG_RST = CFGW'(1);

  logic [CFGW-1:0] set_q [2];
  logic [CFGW-1:0] act_q;
  logic [1:0]      role_q;
  logic            fs1, fs2, pn1, pn2;
  logic [CW-1:0]   cnt_p, cnt_r;
  logic            lv_p, lv_r, lv_raw, lv_r2, half0, prev0;
  logic            run_q, g0_q, g1_q;
  logic            int0, int1;

  wire [CFGW-1:0] pend  = fs2 ? set_q[0] : set_q[1];
  wire [PW-1:0]   p_act = act_q[PW-1:0];
  wire [SW-1:0]   s0    = act_q[PW +: SW];
  wire [SW-1:0]   s1    = act_q[PW+SW +: SW];
  wire [CW-1:0]   half_n = (p_act == '0) ? CW'(2) : CW'({p_act, 1'b0});

  always_comb begin
    case (s0)
      2'd1:    int0 = lv_raw;
      2'd2:    int0 = lv_r;
      default: int0 = lv_p;
    endcase
    case (s1)
      2'd0:    int1 = lv_raw;
      2'd1:    int1 = lv_r2;
      2'd2:    int1 = int0;
      default: int1 = half0;
    endcase
  end

  wire ck_role = role_q == ROLE_CK;
  wire int1_u  = ck_role & int1;
  wire quiet   = !int0 && !int1_u;
  wire pd_req  = (role_q == ROLE_PD) && !pn2;
  wire en_req  = !((role_q != ROLE_PD) && !ck_role && !pn2);
  wire run_d   = quiet ? !pd_req : run_q;
  wire swap    = quiet && (pend != act_q);
  wire clr     = swap || !run_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      set_q[0] <= CFG_RST;  set_q[1] <= CFG_RST;  act_q <= CFG_RST;
      role_q <= 2'd0;
      fs1 <= 1'b1;  fs2 <= 1'b1;  pn1 <= 1'b1;  pn2 <= 1'b1;
      cnt_p <= '0;  cnt_r <= '0;
      lv_p <= 1'b0;  lv_r <= 1'b0;  lv_raw <= 1'b0;  lv_r2 <= 1'b0;
      half0 <= 1'b0;  prev0 <= 1'b0;
      run_q <= 1'b1;  g0_q <= 1'b1;  g1_q <= 1'b1;
    end else begin
      fs1 <= fsel;     fs2 <= fs1;
      pn1 <= mpin_in;  pn2 <= pn1;
      if (wr_en) begin
        case (wr_addr)
          2'd0:    set_q[0] <= wr_data;
          2'd1:    set_q[1] <= wr_data;
          2'd2:    role_q   <= wr_data[1:0];
          default: ;
        endcase
      end
      run_q <= run_d;
      if (swap) act_q <= pend;
      if (clr) begin
        cnt_p <= '0;  cnt_r <= '0;
        lv_p <= 1'b0;  lv_r <= 1'b0;  lv_raw <= 1'b0;  lv_r2 <= 1'b0;
        half0 <= 1'b0;  prev0 <= 1'b0;
      end else begin
        if (pll_tick) begin
          if (cnt_p == half_n - CW'(1)) begin
            cnt_p <= '0;
            lv_p  <= ~lv_p;
          end else cnt_p <= cnt_p + CW'(1);
        end
        if (ref_tick) begin
          if (cnt_r == half_n - CW'(1)) begin
            cnt_r <= '0;
            lv_r  <= ~lv_r;
          end else cnt_r <= cnt_r + CW'(1);
          lv_raw <= ~lv_raw;
          if (lv_raw) lv_r2 <= ~lv_r2;
        end
        if (int0 && !prev0) half0 <= ~half0;
        prev0 <= int0;
      end
      if (!int0)   g0_q <= en_req;
      if (!int1_u) g1_q <= en_req;
    end
  end

  assign clk0_o   = int0 & g0_q;
  assign mpin_out = int1_u & g1_q;
  assign mpin_oe  = ck_role;

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_p < half_n && cnt_r < half_n);
  p_swap_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_q) |-> (!$past(clk0_o) && !$past(mpin_out)));
  p_gate_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(g0_q) |-> !$past(clk0_o));
  p_pd_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (!clk0_o && !mpin_out));
endmodule

// File: tb/clk_out_router_bench.sv
`timescale 1ns/1ps
module clk_out_router_bench;
  logic clk = 0, rst_n = 0, ref_tick = 0, pll_tick = 0, fsel = 1, mpin_in = 1, wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [8:0] wr_data = 0;
  logic clk0_o, mpin_out, mpin_oe;
  int checks = 0, errors = 0, cyc = 0;

  always #2.5 clk = ~clk;

  clk_out_router u_clk_out_router (.*);

  // behavioural reference state
  int sp[2], ss0[2], ss1[2], mrole, ap, as0, as1;
  int rp, rr;
  bit lp, lr, lraw, lr2, h0, pv0, mrun, mg0, mg1, ms1, ms2, me1, me2;

  function automatic int hl(int p); return (p == 0) ? 2 : 2*p; endfunction
  function automatic bit m_int0();
    return (as0 == 1) ? lraw : (as0 == 2) ? lr : lp;
  endfunction
  function automatic bit m_int1();
    case (as1) 0: return lraw; 1: return lr2; 2: return m_int0(); default: return h0; endcase
  endfunction
  function automatic bit m_c0(); return m_int0() && mg0; endfunction
  function automatic bit m_c1(); return (mrole == 2) && m_int1() && mg1; endfunction

  task automatic m_reset();
    for (int i = 0; i < 2; i++) begin sp[i] = 1; ss0[i] = 0; ss1[i] = 0; end
    mrole = 0; ap = 1; as0 = 0; as1 = 0; rp = 2; rr = 2;
    {lp, lr, lraw, lr2, h0, pv0} = '0;
    {mrun, mg0, mg1, ms1, ms2, me1, me2} = '1;
  endtask

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  task automatic m_advance();
    bit o0, o1, quiet, pdr, enr, nrun, sw;
    int ps;
    o0 = m_int0(); o1 = (mrole == 2) && m_int1();
    quiet = !o0 && !o1;
    pdr = (mrole == 1) && !me2;
    enr = !((mrole == 0 || mrole == 3) && !me2);
    nrun = quiet ? !pdr : mrun;
    ps = ms2 ? 0 : 1;
    sw = quiet && (sp[ps] != ap || ss0[ps] != as0 || ss1[ps] != as1);
    if (!o0) mg0 = enr;
    if (!o1) mg1 = enr;
    if (sw) begin ap = sp[ps]; as0 = ss0[ps]; as1 = ss1[ps]; end
    if (sw || !nrun) begin
      rp = hl(ap); rr = hl(ap); {lp, lr, lraw, lr2, h0, pv0} = '0;
    end else begin
      if (pll_tick) begin rp--; if (rp == 0) begin lp = !lp; rp = hl(ap); end end
      if (ref_tick) begin
        rr--; if (rr == 0) begin lr = !lr; rr = hl(ap); end
        if (lraw) lr2 = !lr2;
        lraw = !lraw;
      end
      if (o0 && !pv0) h0 = !h0;
      pv0 = o0;
    end
    mrun = nrun;
    if (wr_en) begin
      if (wr_addr < 2) begin
        sp[wr_addr] = wr_data[4:0]; ss0[wr_addr] = wr_data[6:5]; ss1[wr_addr] = wr_data[8:7];
      end else if (wr_addr == 2) mrole = wr_data[1:0];
    end
    ms2 = ms1; ms1 = fsel; me2 = me1; me1 = mpin_in;
  endtask

  task automatic step();
    check("R2 model clk0", clk0_o, m_c0());
    check("R4 model mpin_out", mpin_out, m_c1());
    check("R10 model mpin_oe", mpin_oe, mrole == 2);
    pll_tick = (cyc % 2 == 0);
    ref_tick = (cyc % 3 == 0);
    m_advance();
    cyc++;
    @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    wr_en = 1; wr_addr = 2'(a); wr_data = 9'(d);
    step();
    wr_en = 0;
  endtask

  function automatic int cfg(int s1, int s0, int p); return (s1 << 7) | (s0 << 5) | p; endfunction

  task automatic measure(string tag, bit which, int exp);
    int rises = 0, last = 0, per = -1, n = 0;
    bit prev = which ? mpin_out : clk0_o;
    while (rises < 3 && n < 600) begin
      step(); n++;
      if ((which ? mpin_out : clk0_o) && !prev) begin
        rises++;
        if (rises == 3) per = n - last;
        last = n;
      end
      prev = which ? mpin_out : clk0_o;
    end
    check(tag, per, exp);
  endtask

  task automatic count_high(string tag, int n);
    int hi = 0;
    for (int i = 0; i < n; i++) begin step(); hi += int'(clk0_o) + int'(mpin_out); end
    check(tag, hi, 0);
  endtask

  initial begin
    #(5.0 * 180000);
    errors++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_reset();
    repeat (4) @(negedge clk);
    rst_n = 1;
    check("R1 reset clk0", clk0_o, 0);
    check("R1 reset mpin_out", mpin_out, 0);
    check("R1 reset mpin_oe", mpin_oe, 0);
    measure("R2 R3 pll div 2", 0, 8);
    wr(0, cfg(0, 1, 1)); measure("R2 raw ref", 0, 6);
    wr(0, cfg(0, 2, 3)); measure("R2 ref div 6", 0, 36);
    wr(0, cfg(0, 0, 0)); measure("R3 div zero as one", 0, 8);
    wr(0, cfg(0, 3, 4)); measure("R2 R3 code3 pll div 8", 0, 32);
    wr(1, cfg(0, 0, 2)); measure("R5 set0 kept while fsel=1", 0, 32);
    fsel = 0; measure("R5 set1 after fsel=0", 0, 16);
    wr(3, cfg(0, 1, 1)); measure("R9 addr3 ignored", 0, 16);
    wr(2, 2);
    check("R10 clock role drives pin", mpin_oe, 1);
    wr(1, cfg(0, 0, 2)); measure("R4 sel1 ref", 1, 6);
    wr(1, cfg(1, 0, 2)); measure("R4 sel1 ref half", 1, 12);
    wr(1, cfg(2, 0, 2)); measure("R4 sel1 clk0", 1, 16);
    wr(1, cfg(3, 0, 2)); measure("R4 sel1 clk0 half", 1, 32);
    mpin_in = 0; measure("R10 pin input ignored in clock role", 1, 32);
    fsel = 1; measure("R6 R5 switch back to set0", 0, 32);
    fsel = 0;
    wr(2, 0); mpin_in = 1;
    check("R10 enable role no drive", mpin_oe, 0);
    measure("R7 enabled", 0, 16);
    mpin_in = 0;
    repeat (24) step();
    count_high("R7 disabled outputs low", 60);
    mpin_in = 1; measure("R7 re-enabled", 0, 16);
    wr(2, 1); mpin_in = 0;
    repeat (24) step();
    count_high("R8 power down outputs low", 60);
    mpin_in = 1; measure("R8 resume", 0, 16);
    wr(1, cfg(0, 1, 2)); measure("R6 reconfig in flight", 0, 6);
    repeat (20) step();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule